// File: doc/BRIEF.md
# Synchronous Burst Read Controller for Pseudo-Static RAM

This block sits on the host side of a pseudo-static RAM that supports clocked burst reads. A user asks for a run of words by giving a start address and a word count. The controller then drives chip select, the address-valid strobe, output enable and the address. It takes each data word from the memory bus when the memory's WAIT line allows it, and hands the word to the user with a one-cycle valid strobe. A done pulse marks the last word.

Several settings are inputs and stay fixed while a burst runs:
- WAIT polarity.
- WAIT timing: WAIT is either aligned with the data or one cycle ahead of it.
- Fixed or variable initial latency, plus a latency code.
- A limit on how many consecutive cycles chip select may stay low.

The memory adds wait states after refresh collisions and at row boundaries, and the controller follows them through WAIT. When the chip-select limit is reached, the controller raises chip select for one cycle. It then restarts the burst at the first word not yet delivered, so long transfers are split into segments. The memory shares the controller's clock.

Top module: `psram_burst_rd`

## Requirements
- R1: While reset is asserted, and after it is released with no request, chip select, address-valid and output enable are all high (inactive). The read-valid, done and busy outputs are low.
- R2: A request with a nonzero count, taken while idle, starts a segment on the next cycle. In that cycle chip select and address-valid are low and the address equals the start address. Address-valid is low for exactly one cycle. In every later cycle of the segment, output enable is low and address-valid is high.
- R3: The WAIT polarity input selects the meaning of the WAIT level. When it is 1, a WAIT level of 1 means "not ready". When it is 0, a WAIT level of 0 means "not ready".
- R4: With WAIT timing aligned (timing input 0), a word is taken at a clock edge where WAIT is sampled inactive.
- R5: With WAIT timing early (timing input 1), a word is taken at a clock edge when WAIT was inactive at the previous edge. The WAIT level at the address-valid edge itself is treated as active.
- R6: In fixed-latency mode with latency code c (c from 1 to 7), the first word of each segment is taken at the (c+1)-th edge after the address-valid edge, whatever WAIT shows before that. Later words in the segment follow WAIT.
- R7: In variable-latency mode, the first word waits for WAIT, however far a refresh collision stretches the initial latency.
- R8: Words reach the user in ascending address order, one read-valid pulse each. Each read-data value equals the data bus as sampled at the edge where that word was taken.
- R9: Chip select never stays low for more than the programmed limit of consecutive cycles. When the limit ends a segment, chip select is high for exactly one cycle. A new segment then starts at the address of the first word not yet delivered.
- R10: The done pulse comes in the same cycle as the read-valid of the last requested word. In that cycle chip select is already high and busy is low, and exactly the requested number of words has been delivered.
- R11: A request with a count of zero gives a done pulse in the next cycle, with no chip-select activity.
- R12: A request made while busy is ignored. The running burst is not disturbed, and no new burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, shared with the memory |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_pol_i | input | 1 | 1: WAIT high means not ready; 0: WAIT low means not ready |
| wait_early_i | input | 1 | 1: WAIT leads data by one cycle; 0: WAIT aligned with data |
| fixed_lat_i | input | 1 | 1: fixed initial latency; 0: variable |
| lat_code_i | input | LCW (3) | Latency code c, giving c+1 clocks |
| ce_limit_i | input | CW (8) | Maximum consecutive chip-select-low cycles |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_addr_i | input | AW (22) | Start word address |
| req_len_i | input | LW (10) | Number of words |
| busy_o | output | 1 | Burst in progress |
| rd_valid_o | output | 1 | Read-data word valid |
| rd_data_o | output | DW (16) | Read-data word |
| done_o | output | 1 | Request complete |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_adv_n_o | output | 1 | Memory address-valid strobe, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | AW (22) | Memory word address |
| mem_dq_i | input | DW (16) | Memory data bus |
| mem_wait_i | input | 1 | Memory WAIT line |

## Verification
The bench builds the controller with its default parameters: 22-bit address, 16-bit data, 10-bit count and 8-bit chip-select limit. The 8-bit limit lets limits of 10 to 20 cycles split bursts of up to 40 words into several segments.

The bench's memory model uses 16-word rows with a two-cycle stall at each row crossing, so most bursts cross a row. Latency codes 1 to 4 are used with random refresh-collision delays of up to three cycles. In both WAIT timings and both polarities, the model shows misleading WAIT levels and junk data outside valid beats. In fixed mode it also shows them before the latency count has run out, so any early or polarity-inverted capture shows up as a data mismatch.

// File: rtl/psram_rd_pkg.sv
package psram_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_RUN,
    ST_GAP
  } rd_state_e;
endpackage

// File: rtl/psram_wait_decode.sv
module psram_wait_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic wait_pol_i,
  input  logic wait_early_i,
  input  logic seg_start_i,
  output logic data_ok_o
);
  logic wait_act;
  logic wait_q;

  assign wait_act = (wait_i == wait_pol_i);

  // early mode: previous edge's WAIT governs this edge; ADV edge counts as busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wait_q <= 1'b1;
    else if (seg_start_i) wait_q <= 1'b1;
    else                  wait_q <= wait_act;
  end

  assign data_ok_o = wait_early_i ? !wait_q : !wait_act;
endmodule

// File: rtl/psram_ce_guard.sv
module psram_ce_guard #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_low_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          limit_hit_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!ce_low_i)     cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // cnt_q low cycles done before this edge; one more would break the limit
  assign cnt_nxt     = {1'b0, cnt_q} + 1'b1;
  assign limit_hit_o = cnt_nxt >= {1'b0, limit_i};
  assign cnt_o       = cnt_q;

  AST_CE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_low_i && limit_i != '0) |-> (cnt_q < limit_i)) else $error("ce low too long"); // R9
endmodule

// File: rtl/psram_beat_track.sv
module psram_beat_track #(
  parameter int AW = 22,
  parameter int LW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          take_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= len_i;
    end else if (take_i) begin
      addr_q <= addr_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == LW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (rem_q != '0)) else $error("word taken past count"); // R8
endmodule

// File: rtl/psram_burst_rd.sv
module psram_burst_rd
  import psram_rd_pkg::*;
#(
  parameter int AW  = 22,
  parameter int DW  = 16,
  parameter int LW  = 10,
  parameter int CW  = 8,
  parameter int LCW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wait_pol_i,
  input  logic           wait_early_i,
  input  logic           fixed_lat_i,
  input  logic [LCW-1:0] lat_code_i,
  input  logic [CW-1:0]  ce_limit_i,
  input  logic           req_valid_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [LW-1:0]  req_len_i,
  output logic           busy_o,
  output logic           rd_valid_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           done_o,
  output logic           mem_ce_n_o,
  output logic           mem_adv_n_o,
  output logic           mem_oe_n_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic [DW-1:0]  mem_dq_i,
  input  logic           mem_wait_i
);
  rd_state_e     state_q, state_d;
  logic          seg_first_q;
  logic          rd_valid_q, done_q;
  logic [DW-1:0] rd_data_q;
  logic          data_ok, limit_hit, last, take, load, zero_req;
  logic [CW-1:0] ce_cnt, lat_clks;

  assign load     = (state_q == ST_IDLE) && req_valid_i;
  assign zero_req = load && (req_len_i == '0);
  assign lat_clks = CW'(lat_code_i) + CW'(1);

  psram_wait_decode i_wait (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wait_i       (mem_wait_i),
    .wait_pol_i   (wait_pol_i),
    .wait_early_i (wait_early_i),
    .seg_start_i  (state_q == ST_ISSUE),
    .data_ok_o    (data_ok)
  );

  psram_ce_guard #(.CW(CW)) i_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_low_i    (!mem_ce_n_o),
    .limit_i     (ce_limit_i),
    .cnt_o       (ce_cnt),
    .limit_hit_o (limit_hit)
  );

  psram_beat_track #(.AW(AW), .LW(LW)) i_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (req_addr_i),
    .len_i  (req_len_i),
    .take_i (take),
    .addr_o (mem_addr_o),
    .last_o (last)
  );

  // fixed latency: first word of a segment lands on the counted edge
  always_comb begin
    take = 1'b0;
    if (state_q == ST_RUN) begin
      if (fixed_lat_i && seg_first_q) take = (ce_cnt == lat_clks);
      else                            take = data_ok;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i && req_len_i != '0) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_RUN;
      ST_RUN: begin
        if (take && last)   state_d = ST_IDLE;
        else if (limit_hit) state_d = ST_GAP;
      end
      ST_GAP:   state_d = ST_ISSUE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      seg_first_q <= 1'b0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= '0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      if (state_q == ST_ISSUE) seg_first_q <= 1'b1;
      else if (take)           seg_first_q <= 1'b0;
      rd_valid_q  <= take;
      if (take) rd_data_q <= mem_dq_i;
      done_q      <= (take && last) || zero_req;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_ce_n_o  = !((state_q == ST_ISSUE) || (state_q == ST_RUN));
  assign mem_adv_n_o = (state_q != ST_ISSUE);
  assign mem_oe_n_o  = (state_q != ST_RUN);
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign done_o      = done_q;

  AST_ADV_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_n_o |=> (mem_adv_n_o && !mem_ce_n_o)) else $error("adv width"); // R2
  AST_CE_FALL_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_n_o) |-> !mem_adv_n_o) else $error("ce fall without adv"); // R9
  AST_GAP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_ce_n_o) && busy_o) |=> (!mem_ce_n_o && !mem_adv_n_o)) else $error("gap length"); // R9
  AST_LAST_DROPS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && rd_valid_o) |-> (mem_ce_n_o && !busy_o)) else $error("ce held after last"); // R10
  AST_VALID_AFTER_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!mem_oe_n_o)) else $error("word outside data phase"); // R8
endmodule

// File: tb/test_psram_burst_rd.sv
module test_psram_burst_rd;
  localparam int AW = 22, DW = 16, LW = 10, CW = 8, LCW = 3;
  localparam int STALL = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           pol, early, fixed;
  logic [LCW-1:0] lat_code;
  logic [CW-1:0]  ce_limit;
  logic           req_valid;
  logic [AW-1:0]  req_addr;
  logic [LW-1:0]  req_len;
  logic           busy, rd_valid, done, ce_n, adv_n, oe_n, mem_wait;
  logic [DW-1:0]  rd_data, mem_dq;
  logic [AW-1:0]  addr;

  psram_burst_rd i_psram_burst_rd (
    .clk_i(clk), .rst_ni(rst_n), .wait_pol_i(pol), .wait_early_i(early),
    .fixed_lat_i(fixed), .lat_code_i(lat_code), .ce_limit_i(ce_limit),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_len_i(req_len),
    .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .done_o(done),
    .mem_ce_n_o(ce_n), .mem_adv_n_o(adv_n), .mem_oe_n_o(oe_n),
    .mem_addr_o(addr), .mem_dq_i(mem_dq), .mem_wait_i(mem_wait)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return a[15:0] ^ {a[21:16], a[21:12]} ^ 16'h5A3C;
  endfunction

  // scoreboard state
  logic [AW-1:0] exp_addr;
  int exp_len, got, segs, ce_run;
  bit done_seen;
  logic prev_ce_n;

  // memory model state
  bit m_on, m_valid;
  int m_delay, m_t;
  logic [AW-1:0] m_cur, s_addr;
  logic s_ce, s_adv;

  task mem_step();
    int  lat;
    bit  vnext, act;
    lat = int'(lat_code) + 1;
    if (!s_ce && !s_adv) begin
      m_on = 1; m_cur = s_addr; m_t = 1;
      m_delay = lat - 1 + (fixed ? 0 : int'($urandom_range(3, 0)));  // refresh collision
    end else if (!s_ce && m_on) begin
      if (m_valid) begin
        m_cur = m_cur + 1'b1;
        m_delay = (m_cur[3:0] == 4'd0) ? STALL : 0;  // 16-word rows
      end else m_delay--;
      m_t++;
    end else m_on = 0;
    m_valid = m_on && (m_delay == 0);
    if (!m_on)        vnext = 0;
    else if (m_valid) vnext = (m_cur[3:0] != 4'hF);
    else              vnext = (m_delay == 1);
    act = early ? !vnext : !m_valid;
    if (m_on && fixed && m_t < lat) act = 0;  // misleading before fixed latency ends
    if (!m_on) act = bit'($urandom_range(1, 0));
    mem_wait = act ? pol : !pol;
    mem_dq   = m_valid ? word_of(m_cur) : DW'($urandom);
  endtask

  initial begin
    prev_ce_n = 1; ce_run = 0; m_on = 0; m_valid = 0;
    mem_wait = 0; mem_dq = '0; exp_addr = '0; exp_len = 0; got = 0; segs = 0; done_seen = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rd_valid) begin
          chk(rd_data == word_of(exp_addr), "R8 data order", int'(rd_data), int'(word_of(exp_addr)));
          exp_addr = exp_addr + 1'b1;
          got++;
          chk(done == (got == exp_len), "R10 done with last word", int'(done), int'(got == exp_len));
          if (done) chk(ce_n && !busy, "R10 release on last word", int'(ce_n), 1);
        end
        if (done) done_seen = 1;
        if (!ce_n) ce_run++;
        else begin
          if (ce_run > 0) chk(ce_run <= int'(ce_limit), "R9 ce low run", ce_run, int'(ce_limit));
          ce_run = 0;
        end
        if (!ce_n && !adv_n) begin
          chk(addr == exp_addr, "R9 issue address", int'(addr), int'(exp_addr));
          chk(prev_ce_n == 1'b1, "R9 gap before issue", int'(prev_ce_n), 1);
          segs++;
        end
        if (!ce_n && adv_n) chk(!oe_n, "R2 oe low in data phase", int'(oe_n), 0);
        prev_ce_n = ce_n;
      end
      s_ce = ce_n; s_adv = adv_n; s_addr = addr;
      @(posedge clk); #1;
      mem_step();
    end
  end

  task automatic do_burst(input logic [AW-1:0] a, input int n, input bit p, input bit e,
                          input bit f, input int code, input int lim, input bit poke);
    @(negedge clk); #1;
    pol = p; early = e; fixed = f; lat_code = LCW'(code); ce_limit = CW'(lim);
    exp_addr = a; exp_len = n; got = 0; segs = 0; done_seen = 0;
    req_valid = 1; req_addr = a; req_len = LW'(n);
    @(negedge clk); #1;
    req_valid = 0;
    chk(!ce_n && !adv_n && addr == a, "R2 issue after request", int'(addr), int'(a));
    if (poke) begin
      @(negedge clk); #1;
      chk(busy == 1'b1, "R12 busy while running", int'(busy), 1);
      req_valid = 1; req_addr = a + 22'h40; req_len = LW'(3);
      @(negedge clk); #1;
      req_valid = 0;
    end
    for (int t = 0; t < 4000 && !done_seen; t++) @(posedge clk);
    chk(got == n, "R10 word count", got, n);
    repeat (3) begin
      @(negedge clk); #1;
      chk(ce_n == 1'b1 && !busy, "R12 idle after done", int'(ce_n), 1);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    finish_test();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; pol = 1; early = 0; fixed = 0; lat_code = 3'd2; ce_limit = 8'd255;
    req_valid = 0; req_addr = '0; req_len = '0;
    repeat (3) @(negedge clk);
    chk(ce_n && adv_n && oe_n, "R1 reset strobes", int'({ce_n, adv_n, oe_n}), 7);
    chk(!rd_valid && !done && !busy, "R1 reset flags", int'({rd_valid, done, busy}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ce_n && adv_n && oe_n && !busy, "R1 idle after reset", int'({ce_n, adv_n, oe_n, busy}), 14);

    // R3 R4 R7: active-low WAIT, aligned, variable latency, crosses a row
    do_burst(22'h00000E, 6, 0, 0, 0, 2, 255, 0);
    // R3 R5 R6: active-high WAIT, early, fixed code 4
    do_burst(22'h012345, 20, 1, 1, 1, 4, 255, 0);
    // R6 R5: fixed code 1, early, active-low
    do_burst(22'h3FFFF8, 12, 0, 1, 1, 1, 255, 0);
    // R9: small limit forces split
    do_burst(22'h000100, 30, 1, 0, 1, 2, 10, 0);
    chk(segs > 1, "R9 burst split", segs, 2);
    // R7: burst of one, variable latency with collision
    do_burst(22'h0A0A0F, 1, 0, 1, 0, 3, 255, 0);
    // R12: request while busy
    do_burst(22'h002000, 8, 1, 0, 0, 2, 255, 1);

    // R11: zero length
    @(negedge clk); #1;
    exp_len = 0; got = 0;
    req_valid = 1; req_addr = 22'h5; req_len = '0;
    @(negedge clk); #1;
    req_valid = 0;
    chk(done == 1'b1, "R11 zero length done", int'(done), 1);
    chk(ce_n == 1'b1 && !busy, "R11 no chip select", int'(ce_n), 1);
    @(negedge clk); #1;
    chk(done == 1'b0 && ce_n, "R11 single pulse", int'(done), 0);

    for (int i = 0; i < 25; i++) begin
      logic [AW-1:0] a;
      int n, code, lim;
      a    = AW'($urandom);
      n    = 1 + int'($urandom_range(39, 0));
      code = 1 + int'($urandom_range(3, 0));
      lim  = ($urandom_range(1, 0) == 1) ? 10 + int'($urandom_range(10, 0)) : 255;
      do_burst(a, n, bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)),
               bit'($urandom_range(1, 0)), code, lim, bit'($urandom_range(1, 0)));
    end
    finish_test();
  end
endmodule